// File: doc/BRIEF.md
# Clock Post-Divider with Output Gating

This block divides a reference oscillator clock by 1, 2, 4, 8 or 16 and presents the result on a clock output. The output has a drive indication next to it. The block's clock `clk` is a half-period timebase, which means it runs at twice the oscillator rate. A divide code `s` gives an output whose high phase lasts `2^s` cycles of `clk` and whose low phase lasts another `2^s` cycles. This gives an exact 50% duty cycle for every ratio, including divide-by-1.

One control pin has two possible roles, chosen by a static configuration bit:
- **Output enable (active-high).** When the pin is low, the output is released to a weak pull-low and the divider keeps running.
- **Power-down (active-low).** When the pin is low, the divider and the oscillator-restart timer are stopped. When the pin returns high, the output stays quiet for a fixed restart interval before it toggles again.

A second configuration bit chooses how stop and start happen:
- **Synchronous mode.** Stop and start happen only on clean period boundaries, decided from a two-flop synchronized copy of the pin.
- **Asynchronous mode.** The pin gates the output combinationally, so stop and start act in the same cycle.

Top module: `clk_postdiv_gate`

## Requirements
- R1: Divide code `div_sel` values 0..4 give high and low phases of exactly `2^div_sel` clk cycles each. Codes 5..7 behave as code 4.
- R2: While `rst` is high and in the first cycle after it, `clk_out` and `out_drive` are both 0.
- R3: A new divide code is taken up only at a rising edge of the divided clock. Every high and low phase has the full length of either the old ratio or the new one, and a phase of the new length starts with a high phase.
- R4: `ctl_pin` high means "run" in both roles. With `cfg_pin_oe`=1 the pin is an enable, and the divider keeps running while it is low. With `cfg_pin_oe`=0 the pin is a power-down, and a low level stops the divider and clears the restart timer.
- R5: In asynchronous enable mode, `out_drive` follows `ctl_pin` in the same cycle. After re-enabling, the output toggles within `2^div_sel` cycles and does not wait for the restart interval.
- R6: In asynchronous power-down mode, `ctl_pin` going low forces `clk_out` and `out_drive` to 0 in the same cycle.
- R7: In synchronous mode (either role), a pin falling during a high phase lets that high phase finish at full length. `out_drive` then drops on the same clock edge as `clk_out` falls.
- R8: In synchronous enable mode, `out_drive` rises on the same edge as a rising edge of `clk_out`, and the first high phase has full length.
- R9: In power-down role (either mode), the first rising edge of `clk_out` after the pin returns high comes at clock edge `2 + RESTART_CYC + 2^div_sel`. Edges are counted from the first edge that follows the pin change.
- R10: Whenever `out_drive` is 0, `clk_out` is 0 (the undriven output reads as weakly pulled low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period timebase, twice the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin | input | 1 | Shared enable / power-down pin, high means run |
| cfg_pin_oe | input | 1 | 1: pin is output enable, 0: pin is power-down |
| cfg_sync | input | 1 | 1: synchronous stop/start, 0: asynchronous |
| div_sel | input | SEL_W | Divide code, ratio 2^code, clamped at MAX_SEL |
| clk_out | output | 1 | Divided clock data |
| out_drive | output | 1 | 1 when the output is actively driven |

## Verification
The hardest situation to reach from the ports is a pin change that lands partway through a high phase while synchronous mode is active. The stimulus waits for the first sample of a fresh high phase and drops the pin right there. This puts the synchronizer delay inside the phase, so a runt pulse or an early release would show up as a short high count. The restart wait is reached by leaving power-down after a completed stop. The bench then counts edges until the first rising edge and compares the count with the exact sum of synchronizer depth, restart count and half period. A ratio change issued mid-phase is followed by recording the next run of pulse lengths.

// File: rtl/cdg_pkg.sv
`timescale 1ns/1ps
package cdg_pkg;
  typedef enum logic {
    ROLE_POWERDOWN = 1'b0,
    ROLE_ENABLE    = 1'b1
  } pin_role_e;
endpackage

// File: rtl/cdg_sync.sv
`timescale 1ns/1ps
module cdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdg_divider.sv
`timescale 1ns/1ps
module cdg_divider #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 4,
  parameter int CNT_W   = MAX_SEL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             ph,
  output logic             at_limit
);
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(MAX_SEL);

  logic [SEL_W-1:0] sel_clamped;
  logic [SEL_W-1:0] sel_act;
  logic [CNT_W:0]   half_len;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  assign sel_clamped = (sel_in > SEL_TOP) ? SEL_TOP : sel_in;
  assign half_len    = (CNT_W+1)'(1) << sel_act;
  assign limit       = CNT_W'(half_len - 1'b1);
  assign at_limit    = (cnt == limit);

  // The ratio is reloaded only when the phase turns high, i.e. at a period start.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      ph      <= 1'b0;
      sel_act <= sel_clamped;
    end else if (at_limit) begin
      cnt <= '0;
      ph  <= ~ph;
      if (!ph) sel_act <= sel_clamped;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: the phase flips only after a full count or when cleared by a stop
  a_r1_flip_at_limit: assert property (@(posedge clk) disable iff (rst)
    (ph != $past(ph)) |-> ($past(at_limit) || !$past(run)));

  // R3: the active ratio moves only at a rising boundary or while stopped
  a_r3_ratio_at_rise: assert property (@(posedge clk) disable iff (rst)
    (sel_act != $past(sel_act)) |-> (!$past(run) || ($past(at_limit) && !$past(ph))));
endmodule

// File: rtl/cdg_restart.sv
`timescale 1ns/1ps
module cdg_restart #(
  parameter int RESTART_CYC = 1000,
  parameter int CW          = $clog2(RESTART_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic ready
);
  localparam logic [CW-1:0] TERM = CW'(RESTART_CYC);

  logic [CW-1:0] cnt;

  assign ready = (cnt == TERM);

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (!ready)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clk_postdiv_gate.sv
`timescale 1ns/1ps
module clk_postdiv_gate
  import cdg_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int MAX_SEL     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_pin,
  input  logic             cfg_pin_oe,
  input  logic             cfg_sync,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_out,
  output logic             out_drive
);
  localparam int CNT_W = MAX_SEL;

  pin_role_e role;
  logic pin_s;
  logic hold;
  logic ready;
  logic run;
  logic div_ph;
  logic div_lim;
  logic rise_pt;
  logic fall_pt;
  logic gate_q;
  logic gate;

  assign role = pin_role_e'(cfg_pin_oe);

  cdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_pin),
    .q   (pin_s)
  );

  // Power-down clears the restart timer; in synchronous mode only once the gate has closed.
  assign hold = (role == ROLE_POWERDOWN) && !pin_s && (cfg_sync ? !gate_q : 1'b1);

  cdg_restart #(.RESTART_CYC(RESTART_CYC)) u_restart (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold),
    .ready (ready)
  );

  assign run = (ready && !hold) || gate_q;

  cdg_divider #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sel_in   (div_sel),
    .ph       (div_ph),
    .at_limit (div_lim)
  );

  assign rise_pt = run && div_lim && !div_ph;
  assign fall_pt = run && div_lim &&  div_ph;

  always_ff @(posedge clk) begin
    if (rst || !cfg_sync)               gate_q <= 1'b0;
    else if (rise_pt && pin_s && ready) gate_q <= 1'b1;
    else if (fall_pt && !pin_s)         gate_q <= 1'b0;
  end

  assign gate      = cfg_sync ? gate_q : (ctl_pin && ready);
  assign clk_out   = div_ph && gate;
  assign out_drive = gate;

  // R8: in synchronous mode the gate moves only on an edge of the divided phase
  a_r8_gate_on_edge: assert property (@(posedge clk) disable iff (rst)
    (cfg_sync && $past(cfg_sync) && (gate_q != $past(gate_q))) |-> (div_ph != $past(div_ph)));

  // R7: a synchronous close happens exactly as the high phase ends
  a_r7_close_after_high: assert property (@(posedge clk) disable iff (rst)
    (cfg_sync && $fell(gate_q)) |-> ($past(div_ph) && !div_ph));

  // R9: while held in power-down the divider phase stays low
  a_r9_quiet_in_pd: assert property (@(posedge clk) disable iff (rst)
    (hold && !gate_q) |=> !div_ph);
endmodule

// File: tb/tb_clk_postdiv_gate.sv
`timescale 1ns/1ps
module tb_clk_postdiv_gate;
  localparam int RST_CYC = 24;
  localparam real TCK    = 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_pin = 1'b1;
  logic       cfg_pin_oe = 1'b1;
  logic       cfg_sync = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic       clk_out;
  logic       out_drive;

  int checks = 0;
  int errors = 0;
  int undriven_high = 0;

  always #(TCK/2) clk = ~clk;

  clk_postdiv_gate #(.SEL_W(3), .MAX_SEL(4), .SYNC_STAGES(2), .RESTART_CYC(RST_CYC)) dut (
    .clk        (clk),
    .rst        (rst),
    .ctl_pin    (ctl_pin),
    .cfg_pin_oe (cfg_pin_oe),
    .cfg_sync   (cfg_sync),
    .div_sel    (div_sel),
    .clk_out    (clk_out),
    .out_drive  (out_drive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int n = 0;
    while (clk_out && n < 4000) begin @(negedge clk); n++; end
    while (!clk_out && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (!clk_out && lo < 100) begin lo++; @(negedge clk); end
  endtask

  task automatic stop_sync(input string req);
    int hi = 0;
    wait_rise();
    ctl_pin = 1'b0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 4, {req, " high phase completes"}, hi, 4);
    chk(out_drive == 1'b0, {req, " drive drops with falling edge"}, out_drive, 0);
  endtask

  task automatic restart_count(input int half, input string req);
    int n = 0;
    ctl_pin = 1'b1;
    do begin @(negedge clk); n++; end while (!clk_out && n < 5000);
    chk(n == 2 + RST_CYC + half, req, n, 2 + RST_CYC + half);
  endtask

  always @(negedge clk) if (!rst && !out_drive && clk_out) undriven_high++;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, lo, n;
    int lvl [9];
    int len [9];
    int first8;
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0 && out_drive == 1'b0, "R2 outputs in reset", {clk_out, out_drive}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b0 && out_drive == 1'b0, "R2 outputs after reset", {clk_out, out_drive}, 0);

    // R1 R4: sweep roles, modes and all codes with the pin at "run"
    for (int oe = 0; oe < 2; oe++)
      for (int sy = 0; sy < 2; sy++)
        for (int s = 0; s < 8; s++) begin
          int h;
          cfg_pin_oe = oe[0];
          cfg_sync   = sy[0];
          div_sel    = s[2:0];
          repeat (80) @(negedge clk);
          h = 1 << ((s > 4) ? 4 : s);
          measure(hi, lo);
          chk(hi == h, $sformatf("R1 R4 high oe=%0d sync=%0d code=%0d", oe, sy, s), hi, h);
          chk(lo == h, $sformatf("R1 R4 low oe=%0d sync=%0d code=%0d", oe, sy, s), lo, h);
        end

    // R7 R8: synchronous enable role
    cfg_pin_oe = 1'b1; cfg_sync = 1'b1; div_sel = 3'd2;
    repeat (60) @(negedge clk);
    stop_sync("R7 enable role");
    repeat (10) @(negedge clk);
    chk(out_drive == 1'b0 && clk_out == 1'b0, "R10 disabled output low", {clk_out, out_drive}, 0);
    ctl_pin = 1'b1;
    n = 0;
    while (!out_drive && n < 200) begin @(negedge clk); n++; end
    chk(clk_out == 1'b1, "R8 drive rises with clock edge", clk_out, 1);
    hi = 0;
    while (clk_out && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 4, "R8 first high phase full", hi, 4);

    // R7 R9: synchronous power-down role
    cfg_pin_oe = 1'b0;
    repeat (60) @(negedge clk);
    stop_sync("R7 power-down role");
    repeat (10) @(negedge clk);
    chk(out_drive == 1'b0 && clk_out == 1'b0, "R10 powered-down output low", {clk_out, out_drive}, 0);
    restart_count(4, "R9 sync restart edge");

    // R6 R9: asynchronous power-down
    cfg_sync = 1'b0; div_sel = 3'd1;
    repeat (60) @(negedge clk);
    wait_rise();
    ctl_pin = 1'b0;
    #1;
    chk(clk_out == 1'b0, "R6 clock stops at once", clk_out, 0);
    chk(out_drive == 1'b0, "R6 drive released at once", out_drive, 0);
    repeat (10) @(negedge clk);
    restart_count(2, "R9 async restart edge");

    // R5 R4: asynchronous enable, divider keeps running
    cfg_pin_oe = 1'b1;
    repeat (40) @(negedge clk);
    ctl_pin = 1'b0;
    #1;
    chk(out_drive == 1'b0 && clk_out == 1'b0, "R5 disable same cycle", {clk_out, out_drive}, 0);
    repeat (20) @(negedge clk);
    ctl_pin = 1'b1;
    #1;
    chk(out_drive == 1'b1, "R5 enable same cycle", out_drive, 1);
    n = 0;
    while (!clk_out && n < 100) begin @(negedge clk); n++; end
    chk(n <= 2, "R5 R4 toggles without restart wait", n, 2);

    // R3: ratio change issued mid-phase in synchronous enable mode
    cfg_sync = 1'b1; div_sel = 3'd1;
    repeat (40) @(negedge clk);
    @(negedge clk);
    div_sel = 3'd3;
    for (int i = 0; i < 9; i++) begin
      lvl[i] = clk_out;
      len[i] = 0;
      while (clk_out == lvl[i][0] && len[i] < 100) begin len[i]++; @(negedge clk); end
    end
    first8 = -1;
    for (int i = 1; i < 9; i++) begin
      chk(len[i] == 2 || len[i] == 8, $sformatf("R3 phase %0d full length", i), len[i], 8);
      if (first8 < 0 && len[i] == 8) first8 = i;
    end
    chk(first8 > 0 && lvl[first8] == 1, "R3 new ratio starts high", (first8 > 0) ? lvl[first8] : -1, 1);
    for (int i = 4; i < 9; i++)
      chk(len[i] == 8, $sformatf("R3 settled phase %0d", i), len[i], 8);

    chk(undriven_high == 0, "R10 never high while undriven", undriven_high, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule